// File: doc/BRIEF.md
# Two-wire serial EEPROM slave

This block is the device side of a 256-byte serial EEPROM on a two-wire bus. It watches the clock line (SCL) and the data line (SDA) through the system clock, and it answers by pulling SDA low through an open-drain enable. Three strap inputs set the low bits of its bus address, so up to eight of these devices can share one pair of wires.

A master sends a start condition and then an address byte. If the address matches, the slave acknowledges. For a write, the master then sends a word address and one data byte. The byte is stored when a stop condition follows. For a random read, the master first writes only a word address, then sends a repeated start and the address byte with the read bit set. The slave then shifts out the byte at that pointer. After each stored write the slave is busy for a programmed number of clock cycles. While busy it acknowledges nothing, so a master can poll it until it answers.

Top module: `ser_eeprom_slave`

## Requirements
- R1: An address byte is acknowledged only when its upper seven bits equal 1010 followed by strap_i[2:0] (MSB first), bit 0 being read (1) or write (0); any other address byte leaves SDA released during the ninth clock.
- R2: Incoming bits are taken on SCL rising edges, and the slave changes its SDA drive only while SCL is low, except that a start or stop releases it.
- R3: SDA falling while SCL is high is a start, which restarts byte framing at the address byte; SDA rising while SCL is high is a stop, which returns the slave to idle. A transfer broken off by a stop in mid-byte leaves the slave ready for the next start.
- R4: The slave pulls SDA low for the whole ninth clock after a matching address byte, after the word address byte, and after the first write data byte.
- R5: A stop that follows a complete, acknowledged write data byte stores that byte at the word address. For PROG_CYCLES system clock cycles after that stop, no address byte is acknowledged.
- R6: A write that carries only a word address and then ends with a stop sets the internal pointer, leaves the memory unchanged and starts no busy period.
- R7: After an address byte with the read bit set, the slave drives the byte at the pointer MSB first, one bit per SCL low period. It then releases SDA for the master's acknowledge clock. After the master's not-acknowledge and a stop it is idle again. The pointer does not advance.
- R8: A write data byte that is followed by a repeated start instead of a stop is discarded and starts no busy period.
- R9: In reset and right after it, SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_i | input | 3 | Hardware address straps, low three bits of the device address |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench runs random byte writes and random reads at random word addresses, including the first and last addresses, with wanted values of 0x80 and 0x01 so that a reversed bit order shows up. It polls straight after a stored write. A slave that acknowledges while busy, or that never becomes busy, fails that check. It sends address bytes with a wrong strap value and with a wrong four-bit prefix. A slave that answers those would put a second device on the bus. It then runs a pointer-only write followed by a current-pointer read, and a data byte cut short by a repeated start. A slave that stores on a start instead of a stop, or that does not keep the pointer separate from the store, returns the wrong byte or stays busy. Finally it drops a stop into the middle of an address byte. A slave with stale framing then misreads the next transfer.

// File: rtl/ser_eeprom_slave.sv
module ser_eeprom_slave #(
  parameter int PROG_CYCLES = 1250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] strap_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe
);
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int BW    = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WADR, S_WDAT, S_RD, S_WAIT} st_t;

  st_t           state;
  logic [2:0]    scl_s, sda_s;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg, pend;
  logic          pend_v, drive;
  logic [AW-1:0] ptr;
  logic [BW-1:0] busy_cnt;
  logic [7:0]    mem [DEPTH];

  wire start_det = scl_s[1] & scl_s[2] & sda_s[2] & ~sda_s[1];
  wire stop_det  = scl_s[1] & scl_s[2] & ~sda_s[2] & sda_s[1];
  wire rise      = scl_s[1] & ~scl_s[2];
  wire fall      = ~scl_s[1] & scl_s[2];
  wire framed    = (state != S_IDLE) && (state != S_WAIT);
  wire busy      = busy_cnt != '0;
  wire dev_hit   = shreg[7:1] == {4'b1010, strap_i};

  assign sda_oe = drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 3'b111;
      sda_s <= 3'b111;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      pend     <= '0;
      pend_v   <= 1'b0;
      drive    <= 1'b0;
      ptr      <= '0;
      busy_cnt <= '0;
    end else begin
      if (busy) busy_cnt <= busy_cnt - BW'(1);
      if (start_det) begin
        state  <= S_DEV;
        bitcnt <= '0;
        drive  <= 1'b0;
        pend_v <= 1'b0;
      end else if (stop_det) begin
        state  <= S_IDLE;
        bitcnt <= '0;
        drive  <= 1'b0;
        pend_v <= 1'b0;
        if (pend_v) busy_cnt <= BW'(PROG_CYCLES);
      end else if (rise && framed) begin
        if (bitcnt == 4'd8) bitcnt <= 4'd9;
        else if (bitcnt < 4'd8) begin
          bitcnt <= bitcnt + 4'd1;
          if (state != S_RD) shreg <= {shreg[6:0], sda_s[1]};
        end
      end else if (fall && framed) begin
        if (bitcnt == 4'd8) begin
          case (state)
            S_DEV:   if (dev_hit && !busy) drive <= 1'b1; else state <= S_IDLE;
            S_WADR:  begin drive <= 1'b1; ptr <= shreg; end
            S_WDAT:  begin drive <= 1'b1; pend <= shreg; pend_v <= 1'b1; end
            default: drive <= 1'b0;
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          drive  <= 1'b0;
          case (state)
            S_DEV:
              if (shreg[0]) begin
                state <= S_RD;
                shreg <= mem[ptr];
                drive <= ~mem[ptr][7];
              end else state <= S_WADR;
            S_WADR:  state <= S_WDAT;
            default: state <= S_WAIT;
          endcase
        end else if (state == S_RD && bitcnt != '0) begin
          shreg <= {shreg[6:0], 1'b0};
          drive <= ~shreg[6];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && stop_det && pend_v) mem[ptr] <= pend;
  end

  assert_no_ack_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state == S_DEV) |-> !sda_oe);
  assert_busy_needs_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !stop_det) |=> !busy);
  assert_still_when_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s[1] && scl_s[2] && !start_det && !stop_det) |=> $stable(sda_oe));
  assert_idle_after_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> state == S_IDLE);
  assert_ptr_only_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_WADR) |=> $stable(ptr));
  assert_nack_foreign_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DEV && fall && bitcnt == 4'd8 && !dev_hit) |=> !sda_oe);
endmodule

// File: tb/test_ser_eeprom_slave.sv
`timescale 1ns/1ps
module test_ser_eeprom_slave;
  localparam int PROG = 300;
  localparam int H = 4;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_oe;
  wire  sda_bus = ~(m_low | sda_oe);
  int checks = 0, errors = 0, r2_viol = 0;
  logic [7:0] model [256];
  logic scl_last = 1'b1, oe_last = 1'b0;

  always #4 clk = ~clk;

  ser_eeprom_slave #(.PROG_CYCLES(PROG)) i_ser_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe));

  always @(negedge clk) begin
    if (rst_n && scl && scl_last && sda_oe != oe_last) r2_viol++;
    scl_last <= scl;
    oe_last  <= sda_oe;
  end

  function automatic logic [7:0] dev(input logic [2:0] s, input logic rw);
    return {4'b1010, s, rw};
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start();
    m_low = 1'b0; wt(H); scl = 1'b1; wt(2*H); m_low = 1'b1; wt(2*H); scl = 1'b0; wt(H);
  endtask

  task automatic m_stop();
    m_low = 1'b1; wt(H); scl = 1'b1; wt(2*H); m_low = 1'b0; wt(2*H);
  endtask

  task automatic m_bit(input logic b, output logic s);
    m_low = ~b; wt(H); scl = 1'b1; wt(H); s = sda_bus; wt(H); scl = 1'b0; wt(H);
  endtask

  task automatic m_wbyte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) m_bit(b[i], s);
    m_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic m_rbyte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin m_bit(1'b1, s); b[i] = s; end
    m_bit(~mack, s);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    logic k;
    m_start();
    m_wbyte(dev(strap, 1'b0), k); chk(k, "R4 write address ack", k, 1);
    m_wbyte(a, k);                chk(k, "R4 word address ack", k, 1);
    m_wbyte(d, k);                chk(k, "R4 data byte ack", k, 1);
    m_stop();
    model[a] = d;
  endtask

  task automatic do_read(input logic [7:0] a, input string req);
    logic k; logic [7:0] d;
    m_start();
    m_wbyte(dev(strap, 1'b0), k); chk(k, "R6 dummy write ack", k, 1);
    m_wbyte(a, k);                chk(k, "R6 pointer ack", k, 1);
    m_start();
    m_wbyte(dev(strap, 1'b1), k); chk(k, "R7 read address ack", k, 1);
    m_rbyte(1'b0, d);
    m_stop();
    chk(d == model[a], req, d, model[a]);
  endtask

  initial begin
    logic k; logic [7:0] a, b, d;
    void'($urandom(32'd1234));
    wt(3);
    chk(sda_oe == 1'b0, "R9 released in reset", sda_oe, 0);
    wt(5); rst_n = 1'b1; wt(4);
    chk(sda_oe == 1'b0 && sda_bus, "R9 released after reset", sda_oe, 0);

    do_write(8'h00, 8'h80); wt(PROG + 40);
    do_write(8'hFF, 8'h01); wt(PROG + 40);
    do_read(8'h00, "R7 MSB first 0x80 at first address");
    do_read(8'hFF, "R7 MSB first 0x01 at last address");

    for (int n = 0; n < 6; n++) begin
      a = 8'($urandom); d = 8'($urandom);
      do_write(a, d); wt(PROG + 40);
      do_read(a, "R5 R7 random write then read");
    end

    a = 8'($urandom); d = 8'($urandom);
    do_write(a, d);
    m_start(); m_wbyte(dev(strap, 1'b0), k); m_stop();
    chk(!k, "R5 no ack while programming", k, 0);
    wt(PROG + 40);
    m_start(); m_wbyte(dev(strap, 1'b0), k); m_stop();
    chk(k, "R5 ack after programming time", k, 1);
    do_read(a, "R5 polled write stored");

    m_start(); m_wbyte(dev(strap ^ 3'b010, 1'b0), k); m_stop();
    chk(!k, "R1 wrong strap not acked", k, 0);
    m_start(); m_wbyte({4'b1011, strap, 1'b1}, k); m_stop();
    chk(!k, "R1 wrong prefix not acked", k, 0);
    strap = 3'b010;
    do_write(8'h5A, 8'hC3); wt(PROG + 40);
    do_read(8'h5A, "R1 new strap value answered");

    b = 8'h5A;
    m_start(); m_wbyte(dev(strap, 1'b0), k); m_wbyte(a, k); m_stop();
    m_start(); m_wbyte(dev(strap, 1'b1), k);
    chk(k, "R6 no busy after pointer-only write", k, 1);
    m_rbyte(1'b0, d); m_stop();
    chk(d == model[a], "R6 current pointer read unchanged", d, model[a]);

    m_start(); m_wbyte(dev(strap, 1'b0), k); m_wbyte(b, k); m_wbyte(~model[b], k);
    m_start(); m_stop();
    m_start(); m_wbyte(dev(strap, 1'b0), k); m_stop();
    chk(k, "R8 no busy after cut write", k, 1);
    do_read(b, "R8 cut write not stored");

    m_start();
    for (int i = 7; i >= 4; i--) m_bit(dev(strap, 1'b0) >> i, k);
    m_stop();
    do_read(a, "R3 recovery after stop in mid byte");

    chk(r2_viol == 0, "R2 drive still while SCL high", r2_viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule